// File: doc/BRIEF.md
# SPI Bulk Write Data Packet Framer

This block produces the data phase of a host-side block write over SPI. A transfer starts with a total byte count, a packet-size code and a CRC-enable flag. The block then takes the payload bytes from a valid/ready byte stream and splits them into packets. Each packet opens with a header byte that tells the slave where the packet sits in the transfer. When CRC is enabled, each packet's payload is followed by two CRC placeholder bytes. All bytes go to the SPI shifter through a valid/ready byte port.

Once the last packet has gone out, the block stops transmitting. It then collects the slave's data-response bytes, which arrive on a received-byte strobe, and checks the tail of that response. The result is reported as a one-cycle done or error pulse. Issuing the command and retrying a failed transfer are handled elsewhere.

Top module: `spi_pkt_framer`

## Requirements
- R1: Every packet starts with the header byte 0xF0 OR order. The order is 1 for the first packet of a transfer that needs more than one packet, 2 for a packet that is neither first nor last, and 3 for the final packet (including a transfer that fits in a single packet).
- R2: The maximum packet size is 256 << code for size codes 0 to 5 (256 to 8192 bytes). Codes 6 and 7 act as 8192. Each packet carries min(remaining bytes, maximum) payload bytes, so the last packet carries the remainder.
- R3: With CRC enabled, exactly two 0x00 bytes follow each packet's payload. With CRC disabled, no bytes follow the payload.
- R4: Payload bytes appear on the output in the order they were accepted on the input. in_ready_o is high only while a payload byte can pass to the shifter in that cycle, and it equals tx_ready_i at that time.
- R5: After the final packet, the block sends nothing more. It reads 2 response bytes when CRC is enabled and 3 bytes when CRC is disabled. The response is good only when its last two bytes are 0xC3 followed by 0x00.
- R6: One cycle after the last response byte is received, done_o pulses for one cycle if the response is good, and err_o pulses for one cycle if it is not. The two never pulse together, and busy_o is low while either one is high.
- R7: A start with a byte count of zero is rejected: err_o pulses in the next cycle, no byte is sent and the block stays idle.
- R8: start_i is ignored while a transfer is in progress.
- R9: After reset, busy_o, tx_valid_o, in_ready_o, done_o and err_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a transfer when the block is idle |
| byte_count_i | input | CNT_W | Total payload bytes for the transfer |
| size_code_i | input | 3 | Maximum packet size code |
| crc_en_i | input | 1 | Adds CRC bytes and selects the response length |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte valid |
| in_ready_o | output | 1 | Payload byte accepted |
| tx_data_o | output | 8 | Byte to the SPI shifter |
| tx_valid_o | output | 1 | tx_data_o valid |
| tx_ready_i | input | 1 | Shifter accepts tx_data_o |
| rx_data_i | input | 8 | Byte received from the slave |
| rx_valid_i | input | 1 | rx_data_i strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse on a good data response |
| err_o | output | 1 | One-cycle pulse on a bad response or a zero count |

## Verification
The assertions check the per-cycle rules on every cycle:
- a header or CRC byte is always one of 0xF1, 0xF2, 0xF3 or 0x00, and it stays stable while the shifter stalls;
- payload is handed straight through whenever it is accepted;
- the port is silent while the block is idle;
- done and error are exclusive one-cycle pulses;
- a zero-count start is rejected.

Only the bench's scenarios can show the rest. That covers the order codes across the packet sequence, packet lengths against the size code (including exact multiples, one-byte remainders and the clamped codes), and the presence or absence of CRC bytes. It also covers response checking with both lengths, and a start pulse that lands in the middle of a transfer.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_CRC0,
    ST_CRC1,
    ST_RSP
  } spf_state_e;

  localparam logic [7:0] HDR_BASE  = 8'hF0;
  localparam logic [7:0] RSP_TOKEN = 8'hC3;
  localparam logic [7:0] RSP_TAIL  = 8'h00;
  localparam logic [7:0] CRC_FILL  = 8'h00;

  localparam logic [1:0] ORD_FIRST = 2'd1;
  localparam logic [1:0] ORD_MID   = 2'd2;
  localparam logic [1:0] ORD_LAST  = 2'd3;
endpackage

// File: rtl/spf_size_decode.sv
// Maps the 3-bit size code to a maximum packet length; codes above MAX_CODE saturate.
module spf_size_decode #(
  parameter int MIN_SHIFT = 8,
  parameter int MAX_CODE  = 5,
  localparam int LEN_W    = MIN_SHIFT + MAX_CODE + 1
) (
  input  logic [2:0]       code_i,
  output logic [LEN_W-1:0] max_len_o
);
  logic [2:0] code_eff;

  assign code_eff = (code_i > 3'(MAX_CODE)) ? 3'(MAX_CODE) : code_i;

  always_comb begin
    max_len_o = '0;
    for (int k = 0; k <= MAX_CODE; k++) begin
      if (code_eff == 3'(k)) max_len_o = LEN_W'(1) << (MIN_SHIFT + k);
    end
  end
endmodule

// File: rtl/spf_pkt_plan.sv
// Works out the order code and length of the next packet.
module spf_pkt_plan #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 14
) (
  input  logic [CNT_W-1:0] remaining_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             first_i,
  output logic [1:0]       order_o,
  output logic [LEN_W-1:0] take_o,
  output logic             last_o
);
  import spf_pkg::*;

  logic [CNT_W-1:0] max_ext;
  logic             fits;

  assign max_ext = {{(CNT_W-LEN_W){1'b0}}, max_len_i};
  assign fits    = remaining_i <= max_ext;
  assign last_o  = fits;
  assign take_o  = fits ? remaining_i[LEN_W-1:0] : max_len_i;
  assign order_o = fits ? ORD_LAST : (first_i ? ORD_FIRST : ORD_MID);
endmodule

// File: rtl/spf_rsp_check.sv
// Counts response bytes and judges the last two.
module spf_rsp_check (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       crc_en_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  output logic       fin_o,
  output logic       ok_o
);
  import spf_pkg::*;

  logic [1:0] cnt_q;
  logic [7:0] prev_q;
  logic [1:0] last_idx;

  assign last_idx = crc_en_i ? 2'd1 : 2'd2;
  assign fin_o    = active_i && rx_valid_i && (cnt_q == last_idx);
  assign ok_o     = (prev_q == RSP_TOKEN) && (rx_data_i == RSP_TAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else if (!active_i) begin
      cnt_q  <= '0;
    end else if (rx_valid_i) begin
      cnt_q  <= cnt_q + 2'd1;
      prev_q <= rx_data_i;
    end
  end
endmodule

// File: rtl/spi_pkt_framer.sv
module spi_pkt_framer #(
  parameter int CNT_W     = 16,
  parameter int MIN_SHIFT = 8,
  parameter int MAX_CODE  = 5,
  localparam int LEN_W    = MIN_SHIFT + MAX_CODE + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic [2:0]       size_code_i,
  input  logic             crc_en_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  import spf_pkg::*;

  spf_state_e       state_q;
  logic [CNT_W-1:0] remaining_q;
  logic [LEN_W-1:0] max_len_q;
  logic [LEN_W-1:0] pkt_left_q;
  logic             first_q, last_pkt_q, crc_q;
  logic             done_q, err_q;

  logic [LEN_W-1:0] max_len_d;
  logic [1:0]       order;
  logic [LEN_W-1:0] take;
  logic             plan_last;
  logic             rsp_fin, rsp_ok;
  logic             pay_phase;
  logic             pay_beat;

  spf_size_decode #(.MIN_SHIFT(MIN_SHIFT), .MAX_CODE(MAX_CODE)) u_dec (
    .code_i    (size_code_i),
    .max_len_o (max_len_d)
  );

  spf_pkt_plan #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_plan (
    .remaining_i (remaining_q),
    .max_len_i   (max_len_q),
    .first_i     (first_q),
    .order_o     (order),
    .take_o      (take),
    .last_o      (plan_last)
  );

  spf_rsp_check u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (state_q == ST_RSP),
    .crc_en_i   (crc_q),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .fin_o      (rsp_fin),
    .ok_o       (rsp_ok)
  );

  assign pay_phase  = (state_q == ST_PAY);
  assign pay_beat   = pay_phase && in_valid_i && tx_ready_i;
  assign in_ready_o = pay_phase && tx_ready_i;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

  always_comb begin
    tx_valid_o = 1'b0;
    tx_data_o  = CRC_FILL;
    unique case (state_q)
      ST_HDR: begin
        tx_valid_o = 1'b1;
        tx_data_o  = HDR_BASE | {6'b0, order};
      end
      ST_PAY: begin
        tx_valid_o = in_valid_i;
        tx_data_o  = in_data_i;
      end
      ST_CRC0, ST_CRC1: tx_valid_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      remaining_q <= '0;
      max_len_q   <= '0;
      pkt_left_q  <= '0;
      first_q     <= 1'b0;
      last_pkt_q  <= 1'b0;
      crc_q       <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (byte_count_i == '0) begin
            err_q <= 1'b1;
          end else begin
            remaining_q <= byte_count_i;
            max_len_q   <= max_len_d;
            crc_q       <= crc_en_i;
            first_q     <= 1'b1;
            state_q     <= ST_HDR;
          end
        end
        ST_HDR: if (tx_ready_i) begin
          pkt_left_q  <= take;
          remaining_q <= remaining_q - {{(CNT_W-LEN_W){1'b0}}, take};
          last_pkt_q  <= plan_last;
          state_q     <= ST_PAY;
        end
        ST_PAY: if (pay_beat) begin
          pkt_left_q <= pkt_left_q - LEN_W'(1);
          if (pkt_left_q == LEN_W'(1)) begin
            first_q <= 1'b0;
            if (crc_q)           state_q <= ST_CRC0;
            else if (last_pkt_q) state_q <= ST_RSP;
            else                 state_q <= ST_HDR;
          end
        end
        ST_CRC0: if (tx_ready_i) state_q <= ST_CRC1;
        ST_CRC1: if (tx_ready_i) state_q <= last_pkt_q ? ST_RSP : ST_HDR;
        ST_RSP: if (rsp_fin) begin
          done_q  <= rsp_ok;
          err_q   <= !rsp_ok;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] byte_count_i,
  input logic [7:0]       in_data_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [7:0]       tx_data_o,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             pay_phase
);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_idle_on_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);

  a_r7_zero_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && byte_count_i == '0) |=> (err_o && !busy_o && !tx_valid_o));

  a_r4_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> (tx_valid_o && tx_data_o == in_data_i));

  a_r1_ctrl_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !pay_phase) |->
      (tx_data_o == 8'hF1 || tx_data_o == 8'hF2 || tx_data_o == 8'hF3 || tx_data_o == 8'h00));

  a_r3_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !pay_phase) |=> (tx_valid_o && $stable(tx_data_o)));

  a_r9_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tx_valid_o && !in_ready_o));
endmodule

bind spi_pkt_framer spf_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_spi_pkt_framer.sv
module sim_spi_pkt_framer;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] byte_count_i = '0;
  logic [2:0]       size_code_i = '0;
  logic             crc_en_i = 1'b0;
  logic [7:0]       in_data_i = '0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [7:0]       tx_data_o;
  logic             tx_valid_o;
  logic             tx_ready_i = 1'b0;
  logic [7:0]       rx_data_i = '0;
  logic             rx_valid_i = 1'b0;
  logic             busy_o, done_o, err_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [7:0] exp_q[$];
  logic [7:0] cap_q[$];

  spi_pkt_framer #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .byte_count_i(byte_count_i),
    .size_code_i(size_code_i), .crc_en_i(crc_en_i), .in_data_i(in_data_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .tx_data_o(tx_data_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .rx_data_i(rx_data_i),
    .rx_valid_i(rx_valid_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run hung act=%0d exp<=200000 cycles", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input logic [7:0] salt);
    return 8'(i * 13) ^ salt;
  endfunction

  function automatic int max_of(input int code);
    return 256 << ((code > 5) ? 5 : code);
  endfunction

  // Expected output stream per R1, R2, R3
  task automatic build_exp(input int cnt, input int code, input bit crc, input logic [7:0] salt);
    int rem = cnt, mx = max_of(code), idx = 0;
    bit first = 1'b1;
    exp_q.delete();
    while (rem > 0) begin
      int n = (rem < mx) ? rem : mx;
      logic [1:0] ord = (rem <= mx) ? 2'd3 : (first ? 2'd1 : 2'd2);
      exp_q.push_back(8'hF0 | {6'b0, ord});
      for (int k = 0; k < n; k++) begin
        exp_q.push_back(pat(idx, salt));
        idx++;
      end
      if (crc) begin
        exp_q.push_back(8'h00);
        exp_q.push_back(8'h00);
      end
      rem -= n;
      first = 1'b0;
    end
  endtask

  task automatic run_xfer(input int cnt, input int code, input bit crc, input bit good,
                          input bit poke, input bit stall);
    logic [7:0] salt = 8'($urandom);
    int idx = 0, cyc = 0, bad_pos = -1;
    logic [7:0] rsp[3];
    int nrsp;
    build_exp(cnt, code, crc, salt);
    cap_q.delete();
    @(negedge clk);
    start_i = 1'b1; byte_count_i = CNT_W'(cnt); size_code_i = 3'(code); crc_en_i = crc;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    while (cap_q.size() < exp_q.size()) begin
      tx_ready_i = stall ? ($urandom % 4 != 0) : 1'b1;
      in_valid_i = stall ? ($urandom % 3 != 0) : 1'b1;
      in_data_i  = pat(idx, salt);
      // R8: start pulse mid-transfer must be ignored
      if (poke && cyc == 20) begin start_i = 1'b1; byte_count_i = 16'd3; end
      else start_i = 1'b0;
      #2;
      if (tx_valid_o && tx_ready_i) cap_q.push_back(tx_data_o);
      if (in_valid_i && in_ready_o) idx++;
      cyc++;
      @(posedge clk);
      @(negedge clk);
    end
    start_i = 1'b0; tx_ready_i = 1'b1; in_valid_i = 1'b1;
    #2;
    chk(!tx_valid_o && busy_o, "R5 nothing sent after last packet", {tx_valid_o, busy_o}, 1);
    tx_ready_i = 1'b0; in_valid_i = 1'b0;
    chk(cap_q.size() == exp_q.size(), "R2 stream length", cap_q.size(), exp_q.size());
    foreach (exp_q[i]) if (bad_pos < 0 && cap_q[i] !== exp_q[i]) bad_pos = i;
    if (bad_pos >= 0)
      chk(1'b0, $sformatf("R1/R3/R4 stream byte %0d", bad_pos), cap_q[bad_pos], exp_q[bad_pos]);
    else
      chk(1'b1, "R1 R3 R4 stream", 0, 0);
    nrsp = crc ? 2 : 3;
    rsp[0] = crc ? 8'hC3 : 8'h5A;
    rsp[1] = crc ? (good ? 8'h00 : 8'h01) : 8'hC3;
    rsp[2] = good ? 8'h00 : 8'h55;
    if (!crc && !good) rsp[1] = 8'h00;
    for (int k = 0; k < nrsp; k++) begin
      @(negedge clk);
      rx_valid_i = 1'b1; rx_data_i = rsp[k];
      #2;
      if (k < nrsp - 1) chk(busy_o && !done_o && !err_o, "R5 wait for all response bytes", busy_o, 1);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid_i = 1'b0;
    #1;
    chk(done_o == good, "R6 done pulse", done_o, good);
    chk(err_o == !good, "R6 err pulse", err_o, !good);
    chk(!busy_o, "R6 idle after response", busy_o, 0);
    @(negedge clk);
    #1;
    chk(!done_o && !err_o, "R6 single-cycle pulse", {done_o, err_o}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !tx_valid_o && !in_ready_o && !done_o && !err_o, "R9 reset state",
        {busy_o, tx_valid_o, in_ready_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R7 zero count
    start_i = 1'b1; byte_count_i = '0;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(err_o && !busy_o && !tx_valid_o, "R7 zero count rejected", {err_o, busy_o, tx_valid_o}, 4);
    @(negedge clk);
    #1;
    chk(!err_o && !busy_o && !tx_valid_o, "R7 stays idle", {err_o, busy_o, tx_valid_o}, 0);

    // Directed corners: R1 R2 R3 R5
    run_xfer(600, 0, 1'b1, 1'b1, 1'b1, 1'b1);   // three packets 256/256/88, R8 poke
    run_xfer(512, 1, 1'b0, 1'b1, 1'b0, 1'b1);   // exact fit, single order 3
    run_xfer(257, 0, 1'b0, 1'b1, 1'b0, 1'b0);   // one-byte remainder
    run_xfer(1, 0, 1'b1, 1'b1, 1'b0, 1'b1);     // one byte
    run_xfer(1500, 2, 1'b1, 1'b0, 1'b0, 1'b1);  // bad response, CRC on
    run_xfer(300, 0, 1'b0, 1'b0, 1'b0, 1'b1);   // bad response, CRC off
    run_xfer(9000, 6, 1'b0, 1'b1, 1'b0, 1'b0);  // R2 clamped code
    run_xfer(8193, 5, 1'b1, 1'b1, 1'b0, 1'b0);  // R2 largest size, remainder 1
    run_xfer(2048, 3, 1'b0, 1'b1, 1'b1, 1'b1);

    // Random mix
    for (int t = 0; t < 8; t++) begin
      int c = 1 + ($urandom % 1400);
      run_xfer(c, $urandom % 2, 1'($urandom), 1'($urandom % 4 != 0), 1'($urandom), 1'b1);
    end

    finish_run();
  end
endmodule